// File: doc/BRIEF.md
# DMA Trigger Source Selector

This block holds one small trigger register per DMA channel. Each register names a peripheral interrupt line that should start a transfer on that channel, and it holds a sticky request flag. When the named line pulses, the flag is latched. The channel then presents a request to the DMA engine until that engine acknowledges it or software clears the flag. Software reaches the registers through a simple register bus. A write to the flag bit can only clear the flag. A single-bit mode lets software touch the flag without disturbing the source code next to it.

Each channel's request and acknowledge form a valid/ready pair. `dma_req[n]` is the valid signal and `dma_ack[n]` is the ready signal. A request, once raised, stays high and stable while no acknowledge arrives, so the engine may apply back-pressure for as long as it needs. An acknowledge taken together with a high request drops the request on the following cycle, unless a new interrupt pulse arrives in that same cycle. An acknowledge taken while the request is low changes nothing.

The register bus runs without wait states. Writes take effect at the clock edge where `bus_wr` is high. Reads return the addressed register combinationally.

Top module: `trig_select_bank`

## Requirements
- R1: After reset, every channel register reads 0x00 and every `dma_req` bit is low.
- R2: The register for channel n sits at byte offset 2*n, and its read value is {flag, 0, select[5:0]}. Writes to odd offsets, or to offsets at or beyond 2*NUM_CH, change no register, and reads at those offsets return 0x00.
- R3: A byte write (`bus_bit` low) loads bits 5..0 into the select field. Bit 6 always reads 0, whatever value was written there.
- R4: A select code k in the range 1..NUM_IRQ routes interrupt line k-1 to the channel. A one-cycle pulse on that line sets the flag, and the flag reads 1 from the next cycle on. Any number of channels may select the same line.
- R5: Select code 0 and every code above NUM_IRQ disable the channel. No interrupt pulse sets the flag, and `dma_req` stays low even when the flag is already 1.
- R6: A software write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged.
- R7: A single-bit write (`bus_bit` high) acts on the flag only, following the R6 rule. The select field keeps its value.
- R8: Once set, the flag stays set on every later cycle until software clears it or the DMA engine acknowledges it, however long that takes.
- R9: `dma_req[n]` equals the flag of channel n ANDed with a select code in the range 1..NUM_IRQ.
- R10: `dma_ack[n]` while the flag is set clears that channel's flag from the next cycle on. It has no effect on other channels, and no effect when the flag is clear.
- R11: If an interrupt pulse that sets the flag lands in the same cycle as a software clear or an acknowledge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_bit | input | 1 | Single-bit access to the flag (bit 7) only |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_pulse | input | NUM_IRQ | Single-cycle peripheral interrupt pulses |
| dma_req | output | NUM_CH | Per-channel transfer request (valid) |
| dma_ack | input | NUM_CH | Per-channel acknowledge from the DMA engine (ready) |

## Verification
The bench builds the block with its defaults: four channels, seven interrupt lines and a 4-bit address. That address space reaches beyond the last register and includes odd offsets, so the ignored-address rule can be tested. Seven lines inside a 6-bit code leave reserved codes such as 8 and 63 available for the disable tests. A vector table steps through the channels with lines that match, lines that do not match, a disabled code and reserved codes. Directed tests then cover same-cycle set/clear races, a flag held through a long stall, and two channels that share one line.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 6;
  localparam int FLAG_BIT = 7;
  localparam int RSVD_BIT = 6;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [REG_W-1:0] reg_t;

  function automatic reg_t pack_reg(input logic flag, input sel_t sel);
    return {flag, 1'b0, sel};
  endfunction
endpackage

// File: rtl/trig_bus_decode.sv
module trig_bus_decode #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] wr_hit
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = addr[ADDR_W-1:1];
  assign aligned = ~addr[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign hit[i]    = aligned && (idx == IDX_W'(i));
    assign wr_hit[i] = wr && hit[i];
  end
endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux
  import trig_pkg::*;
#(
  parameter int NUM_IRQ = 7
) (
  input  sel_t               sel,
  input  logic [NUM_IRQ-1:0] irq,
  output logic               sel_ok,
  output logic               fire
);
  assign sel_ok = (sel != '0) && (sel <= SEL_W'(NUM_IRQ));

  always_comb begin
    fire = 1'b0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (sel == SEL_W'(k + 1)) fire = irq[k];
    end
  end
endmodule

// File: rtl/trig_chan_reg.sv
module trig_chan_reg
  import trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic bit_mode,
  input  sel_t wsel,
  input  logic wflag,
  input  logic set,
  input  logic ack,
  output sel_t sel,
  output logic flag
);
  logic sw_clr;
  logic flag_d;

  assign sw_clr = wr && !wflag;

  always_comb begin
    if (set)                flag_d = 1'b1;
    else if (sw_clr || ack) flag_d = 1'b0;
    else                    flag_d = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      flag <= 1'b0;
    end else begin
      flag <= flag_d;
      if (wr && !bit_mode) sel <= wsel;
    end
  end

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !flag);
  a_r6_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wflag && !set && !ack) |=> (flag == $past(flag)));
  a_r7_bit_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bit_mode) |=> $stable(sel));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack && !sw_clr) |=> flag);
endmodule

// File: rtl/trig_select_bank.sv
module trig_select_bank
  import trig_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_IRQ = 7,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_bit,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_pulse,
  output logic [NUM_CH-1:0]  dma_req,
  input  logic [NUM_CH-1:0]  dma_ack
);
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] wr_hit;
  logic [NUM_CH-1:0] fire;
  logic [NUM_CH-1:0] sel_ok;
  logic [NUM_CH-1:0] flag;
  sel_t              sel [NUM_CH];
  logic              unused_rsvd;

  assign unused_rsvd = bus_wdata[RSVD_BIT];

  trig_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .hit    (hit),
    .wr_hit (wr_hit)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    trig_src_mux #(.NUM_IRQ(NUM_IRQ)) u_mux (
      .sel    (sel[n]),
      .irq    (irq_pulse),
      .sel_ok (sel_ok[n]),
      .fire   (fire[n])
    );

    trig_chan_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_hit[n]),
      .bit_mode (bus_bit),
      .wsel     (bus_wdata[SEL_W-1:0]),
      .wflag    (bus_wdata[FLAG_BIT]),
      .set      (fire[n]),
      .ack      (dma_ack[n]),
      .sel      (sel[n]),
      .flag     (flag[n])
    );

    assign dma_req[n] = flag[n] && sel_ok[n];

    a_r10_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req[n] && dma_ack[n] && !fire[n]) |=> !dma_req[n]);
    a_r5_no_fire_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok[n] && !flag[n]) |=> !flag[n]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit[n]) bus_rdata = pack_reg(flag[n], sel[n]);
    end
  end
endmodule

// File: tb/sim_trig_select_bank.sv
module sim_trig_select_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_bit = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [6:0] irq_pulse = '0;
  logic [3:0] dma_req, dma_ack = '0;

  int checks = 0, failures = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  trig_select_bank u0 (.*);

  // vector: ch[11:10] sel[9:4] line[3:1] expected_flag[0]
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 6'd1,  3'd0, 1'b1},
    {2'd1, 6'd7,  3'd6, 1'b1},
    {2'd2, 6'd3,  3'd4, 1'b0},
    {2'd3, 6'd0,  3'd0, 1'b0},
    {2'd0, 6'd8,  3'd0, 1'b0},
    {2'd1, 6'd63, 3'd6, 1'b0},
    {2'd2, 6'd5,  3'd4, 1'b1},
    {2'd3, 6'd4,  3'd3, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic bm, input logic [3:0] a, input logic [7:0] d,
                     input logic [6:0] irq, input logic [3:0] ack);
    @(negedge clk);
    bus_wr = wr; bus_bit = bm; bus_addr = a; bus_wdata = d; irq_pulse = irq; dma_ack = ack;
    @(negedge clk);
    bus_wr = 0; bus_bit = 0; bus_wdata = 0; irq_pulse = 0; dma_ack = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < 4; c++) begin rd(4'(2*c), rv); check("R1 reg reset", rv, 8'h00); end
    check("R1 req reset", dma_req, 4'h0);

    // Vector walk: R4 R5 R9 R10
    for (int v = 0; v < 8; v++) begin
      logic [1:0] ch; logic [5:0] s; logic [2:0] ln; logic ex;
      {ch, s, ln, ex} = VEC[v];
      cyc(1, 0, 4'(2*ch), {2'b00, s}, 7'h00, 4'h0);
      cyc(0, 0, 4'(2*ch), 8'h00, 7'(1 << ln), 4'h0);
      rd(4'(2*ch), rv);
      check("R4/R5 flag after pulse", rv, {ex, 1'b0, s});
      check("R9 req follows flag", dma_req[ch], ex);
      cyc(0, 0, 4'(2*ch), 8'h00, 7'h00, 4'(1 << ch));
      rd(4'(2*ch), rv);
      check("R10 ack clears", rv, {2'b00, s});
    end

    // R3 bit 6 reads 0
    cyc(1, 0, 4'd0, 8'h7F, 7'h00, 4'h0);
    rd(4'd0, rv); check("R3 bit6 masked", rv, 8'h3F);
    cyc(1, 0, 4'd0, 8'h02, 7'h00, 4'h0);
    rd(4'd0, rv); check("R3 sel load", rv, 8'h02);

    // R6 write of 1 keeps, 0 clears
    cyc(0, 0, 4'd0, 8'h00, 7'h02, 4'h0);
    cyc(1, 0, 4'd0, 8'h82, 7'h00, 4'h0);
    rd(4'd0, rv); check("R6 write 1 keeps", rv, 8'h82);
    cyc(1, 0, 4'd0, 8'h02, 7'h00, 4'h0);
    rd(4'd0, rv); check("R6 write 0 clears", rv, 8'h02);

    // R7 single-bit access
    cyc(0, 0, 4'd0, 8'h00, 7'h02, 4'h0);
    cyc(1, 1, 4'd0, 8'h80, 7'h00, 4'h0);
    rd(4'd0, rv); check("R7 bit write 1", rv, 8'h82);
    cyc(1, 1, 4'd0, 8'h15, 7'h00, 4'h0);
    rd(4'd0, rv); check("R7 bit write 0 keeps sel", rv, 8'h02);

    // R8 sticky through a long stall
    cyc(0, 0, 4'd0, 8'h00, 7'h02, 4'h0);
    repeat (20) @(negedge clk);
    rd(4'd0, rv); check("R8 sticky flag", rv, 8'h82);
    check("R8 req held", dma_req[0], 1'b1);

    // R5/R9 flag kept but channel disabled
    cyc(1, 0, 4'd0, 8'h80, 7'h00, 4'h0);
    rd(4'd0, rv); check("R5 flag kept sel 0", rv, 8'h80);
    check("R5 req low sel 0", dma_req[0], 1'b0);
    cyc(1, 0, 4'd0, 8'h88, 7'h00, 4'h0);
    check("R5 req low reserved", dma_req[0], 1'b0);
    cyc(1, 0, 4'd0, 8'h82, 7'h00, 4'h0);
    check("R9 req back", dma_req[0], 1'b1);

    // R11 set beats software clear and ack
    cyc(1, 0, 4'd0, 8'h02, 7'h00, 4'h0);
    cyc(1, 0, 4'd0, 8'h02, 7'h02, 4'h0);
    rd(4'd0, rv); check("R11 set over sw clear", rv, 8'h82);
    cyc(0, 0, 4'd0, 8'h00, 7'h02, 4'h1);
    rd(4'd0, rv); check("R11 set over ack", rv, 8'h82);

    // R10 ack on another channel has no effect
    cyc(1, 0, 4'd2, 8'h07, 7'h00, 4'h0);
    cyc(0, 0, 4'd0, 8'h00, 7'h40, 4'h0);
    cyc(0, 0, 4'd0, 8'h00, 7'h00, 4'h1);
    rd(4'd2, rv); check("R10 other ack ignored", rv, 8'h87);
    rd(4'd0, rv); check("R10 own ack clears", rv, 8'h02);
    cyc(0, 0, 4'd0, 8'h00, 7'h00, 4'h1);
    rd(4'd0, rv); check("R10 ack with no request", rv, 8'h02);

    // R2 odd and out-of-range offsets
    cyc(1, 0, 4'd1, 8'h05, 7'h00, 4'h0);
    cyc(1, 0, 4'd8, 8'h05, 7'h00, 4'h0);
    rd(4'd0, rv); check("R2 odd write ignored", rv, 8'h02);
    rd(4'd1, rv); check("R2 odd read zero", rv, 8'h00);
    rd(4'd8, rv); check("R2 high read zero", rv, 8'h00);

    // R4 two channels share a line
    cyc(1, 0, 4'd4, 8'h03, 7'h00, 4'h0);
    cyc(1, 0, 4'd6, 8'h03, 7'h00, 4'h0);
    cyc(0, 0, 4'd0, 8'h00, 7'h04, 4'h0);
    rd(4'd4, rv); check("R4 shared line ch2", rv, 8'h83);
    rd(4'd6, rv); check("R4 shared line ch3", rv, 8'h83);

    finish_run();
  end
endmodule